// File: doc/BRIEF.md
# SPI ADC Frame Reader

This block is an SPI master that performs one complete conversion read from a 13-bit serial analog-to-digital converter. A single-cycle `start` request latches a single-ended/differential select and a 3-bit channel number. The block then lowers chip select and runs a fixed frame of 24 serial clocks, organised as three 8-bit segments. During the frame it shifts out a command word and captures the converter's reply.

The command is padded with leading zeros so that the 13 result bits land in fixed positions within the second and third segments. The block drives outgoing data on falling SCLK edges and samples incoming data on rising edges. A parameter selects whether SCLK parks low (mode 0) or high (mode 3). A second parameter sets the number of system clocks per half SCLK period.

When the frame closes, the block presents a two's-complement result and a null-bit error flag, and raises a one-cycle `done` pulse.

Top module: `adc_frame_master`

## Requirements
- R1: After reset, `cs_n` is 1, `busy` is 0, `done` is 0 and `sclk` sits at its idle level.
- R2: Each frame holds `cs_n` at 0 for exactly 24 rising SCLK edges. SCLK does not move while `cs_n` is 1. At least one half SCLK period (HALF_DIV system clocks) passes between the fall of `cs_n` and the first SCLK edge, and the same minimum passes between the last SCLK edge and the rise of `cs_n`.
- R3: Numbering the 24 bits sent on `mosi` from 23 (first) down to 0 (last):
  - bits 23..18 are 0;
  - bit 17 is 1 (the start bit);
  - bit 16 is `sgl_diff`;
  - bits 15..13 are `channel[2]`, `channel[1]`, `channel[0]`;
  - bits 12..0 are 0.
- R4: SCLK idles low when IDLE_HIGH=0 (mode 0) and high when IDLE_HIGH=1 (mode 3). It stays at that level whenever `cs_n` is 1.
- R5: While `cs_n` is low, `mosi` changes only at a falling SCLK edge. `miso` is sampled at each rising edge.
- R6: Number the received bits 23 (first) down to 0 (last). `result` equals received bits 12..0, which are the sign followed by B11..B0. Received bits 23..14 have no effect on `result`.
- R7: `null_err` equals received bit 13 (the null bit, expected to be 0) of the most recent frame.
- R8: `done` is a one-cycle pulse. It arrives with `busy` already 0 and `cs_n` already 1, and `result` and `null_err` are valid in that cycle.
- R9: A `start` that arrives while `busy` is 1 is ignored. No extra frame follows the current one.
- R10: `sgl_diff` and `channel` are latched when `start` is accepted. Changes to them during a frame do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one conversion read (accepted when idle) |
| sgl_diff | input | 1 | Single-ended (1) / differential (0) select |
| channel | input | 3 | Input channel number |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the converter |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse: result valid |
| result | output | 13 | Sign and 12-bit magnitude, two's complement |
| null_err | output | 1 | Null bit of last frame was 1 |

## Verification
The bench builds two copies of the block side by side. The first uses IDLE_HIGH=0 with HALF_DIV=3, which exercises mode 0 with a divided clock so that the lead and lag timing spans several system cycles. The second uses IDLE_HIGH=1 with HALF_DIV=1, which exercises mode 3 at the fastest SCLK the block can produce: every half period is a single system cycle. At that rate the order of the SCLK and data edges is most exposed. A converter model replies with chosen words covering positive, negative and all-ones results and a set null bit. Its first segment and unknown bits are filled with ones so that any leak of them into `result` shows up.

// File: rtl/adc_frame_pkg.sv
// Package: shared constants, state type and command builder for the
// SPI ADC frame reader. Assumes a 24-bit frame and a 13-bit result.
package adc_frame_pkg;
    localparam int FRAME_BITS = 24;
    localparam int RES_BITS   = 13;
    localparam int CH_BITS    = 3;
    localparam int HALF_EDGES = 2 * FRAME_BITS;
    localparam int HCNT_W     = $clog2(HALF_EDGES);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TRAIL = 2'd3
    } frame_st_t;

    // Compose the outgoing word: zero padding, start bit, mode, channel.
    function automatic logic [FRAME_BITS-1:0] build_cmd(
        input logic               sgl,
        input logic [CH_BITS-1:0] ch
    );
        build_cmd = {6'b000000, 1'b1, sgl, ch, 5'b00000, 8'h00};
    endfunction
endpackage

// File: rtl/adc_half_tick.sv
// Module: half-period tick generator. Emits one-cycle ticks every
// HALF_DIV clocks while run is high; restarts its count when run drops.
// Assumes HALF_DIV >= 1.
module adc_half_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Count system clocks within a half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_frame_seq.sv
// Module: frame sequencer. Drives chip select, SCLK and MOSI for one
// 24-clock frame and shifts in MISO on rising edges. Assumes tick comes
// from adc_half_tick and cmd_word is stable in the cycle start is seen.
module adc_frame_seq
    import adc_frame_pkg::*;
#(
    parameter bit IDLE_HIGH = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] cmd_word,
    input  logic                  tick,
    input  logic                  miso,
    output logic                  cs_n,
    output logic                  sclk,
    output logic                  mosi,
    output logic                  busy,
    output logic                  frame_end,
    output logic [FRAME_BITS-1:0] rx_word
);
    localparam logic [HCNT_W-1:0] LAST_HALF = HCNT_W'(HALF_EDGES - 1);

    frame_st_t             state;
    logic [FRAME_BITS-1:0] tx_sr;
    logic [HCNT_W-1:0]     hcnt;

    assign busy      = (state != ST_IDLE);
    assign mosi      = tx_sr[FRAME_BITS-1];
    assign frame_end = (state == ST_TRAIL) && tick;

    // Step the frame: lead gap, 48 half periods, trail gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cs_n    <= 1'b1;
            sclk    <= IDLE_HIGH;
            tx_sr   <= '0;
            rx_word <= '0;
            hcnt    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        tx_sr <= cmd_word;
                        cs_n  <= 1'b0;
                        hcnt  <= '0;
                        state <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        sclk  <= 1'b0;
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!hcnt[0]) begin
                            sclk    <= 1'b1;
                            rx_word <= {rx_word[FRAME_BITS-2:0], miso};
                            hcnt    <= hcnt + 1'b1;
                        end else if (hcnt == LAST_HALF) begin
                            sclk  <= IDLE_HIGH;
                            state <= ST_TRAIL;
                        end else begin
                            sclk  <= 1'b0;
                            tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
                            hcnt  <= hcnt + 1'b1;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        cs_n  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);  // R2
    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sclk == IDLE_HIGH));  // R4
    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mosi) && !$past(cs_n)) |-> $fell(sclk));  // R5
endmodule

// File: rtl/adc_result_reg.sv
// Module: result holder. Captures sign, magnitude and null bit from the
// received word at frame end and raises a one-cycle done pulse.
// Assumes rx_word is complete in the cycle frame_end is high.
module adc_result_reg
    import adc_frame_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_end,
    input  logic [FRAME_BITS-1:0] rx_word,
    output logic [RES_BITS-1:0]   result,
    output logic                  null_err,
    output logic                  done
);
    // Latch the result field and null bit; pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            null_err <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= frame_end;
            if (frame_end) begin
                result   <= rx_word[RES_BITS-1:0];
                null_err <= rx_word[RES_BITS];
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R8
endmodule

// File: rtl/adc_frame_master.sv
// Module: top of the SPI ADC frame reader. Builds the command word,
// runs the frame and presents the registered result.
// Assumes HALF_DIV >= 1; IDLE_HIGH picks mode 3 (1) or mode 0 (0).
module adc_frame_master
    import adc_frame_pkg::*;
#(
    parameter int HALF_DIV  = 4,
    parameter bit IDLE_HIGH = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                sgl_diff,
    input  logic [CH_BITS-1:0]  channel,
    input  logic                miso,
    output logic                cs_n,
    output logic                sclk,
    output logic                mosi,
    output logic                busy,
    output logic                done,
    output logic [RES_BITS-1:0] result,
    output logic                null_err
);
    logic                  tick;
    logic                  frame_end;
    logic [FRAME_BITS-1:0] cmd_word;
    logic [FRAME_BITS-1:0] rx_word;

    assign cmd_word = build_cmd(sgl_diff, channel);

    adc_half_tick #(.HALF_DIV(HALF_DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    adc_frame_seq #(.IDLE_HIGH(IDLE_HIGH)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmd_word  (cmd_word),
        .tick      (tick),
        .miso      (miso),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .mosi      (mosi),
        .busy      (busy),
        .frame_end (frame_end),
        .rx_word   (rx_word)
    );

    adc_result_reg res_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .rx_word   (rx_word),
        .result    (result),
        .null_err  (null_err),
        .done      (done)
    );

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));  // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cs_n && $past(busy)));  // R8
endmodule

// File: tb/adc_frame_master_tb_top.sv
// Converter model: captures MOSI on rising SCLK, drives MISO on falling
// SCLK from a reply word, and records edge counts and lead/lag times.
module adc_slave_model #(
    parameter bit IDLE_HIGH = 1'b0
) (
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        mosi,
    input  logic [23:0] resp,
    output logic        miso,
    output logic [23:0] cmd,
    output int          rises,
    output int          stray,
    output longint      lead_t,
    output longint      lag_t
);
    logic   cs_q   = 1'b1;
    logic   sclk_q = IDLE_HIGH;
    longint t_fall = 0;
    longint t_last = 0;
    bit     seen   = 1'b0;

    initial begin
        miso = 1'b0; cmd = '0; rises = 0; stray = 0; lead_t = 0; lag_t = 0;
    end

    // Track chip select and clock edges in one process.
    always @(cs_n or sclk) begin
        if (cs_q === 1'b1 && cs_n === 1'b0) begin
            rises = 0; cmd = '0; miso = resp[23]; t_fall = $time; seen = 1'b0;
        end else if (cs_q === 1'b0 && cs_n === 1'b1) begin
            lag_t = $time - t_last;
        end else if (sclk !== sclk_q) begin
            if (cs_n === 1'b0) begin
                if (!seen) begin
                    lead_t = $time - t_fall;
                    seen = 1'b1;
                end
                t_last = $time;
                if (sclk === 1'b1) begin
                    cmd = {cmd[22:0], mosi};
                    rises++;
                end else if (rises < 24) begin
                    miso = resp[23 - rises];
                end
            end else begin
                stray++;
            end
        end
        cs_q = cs_n;
        sclk_q = sclk;
    end
endmodule

// Bench: two copies of the reader (mode 0, HALF_DIV=3 and mode 3,
// HALF_DIV=1), directed scenarios, one task each.
module adc_frame_master_tb_top;
    logic clk = 1'b0;
    logic rst_n;
    always #5 clk = ~clk;

    logic        start [2];
    logic        sgl [2];
    logic [2:0]  ch [2];
    logic        miso [2];
    logic        cs_n [2];
    logic        sclk [2];
    logic        mosi [2];
    logic        busy [2];
    logic        done [2];
    logic        null_err [2];
    logic [12:0] result [2];
    logic [23:0] resp [2];
    logic [23:0] cmd [2];
    int          rises [2];
    int          stray [2];
    longint      lead_t [2];
    longint      lag_t [2];

    int errors = 0;
    int checks = 0;

    adc_frame_master #(.HALF_DIV(3), .IDLE_HIGH(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start[0]), .sgl_diff(sgl[0]),
        .channel(ch[0]), .miso(miso[0]), .cs_n(cs_n[0]), .sclk(sclk[0]),
        .mosi(mosi[0]), .busy(busy[0]), .done(done[0]),
        .result(result[0]), .null_err(null_err[0]));

    adc_frame_master #(.HALF_DIV(1), .IDLE_HIGH(1'b1)) dut_m3_i (
        .clk(clk), .rst_n(rst_n), .start(start[1]), .sgl_diff(sgl[1]),
        .channel(ch[1]), .miso(miso[1]), .cs_n(cs_n[1]), .sclk(sclk[1]),
        .mosi(mosi[1]), .busy(busy[1]), .done(done[1]),
        .result(result[1]), .null_err(null_err[1]));

    adc_slave_model #(.IDLE_HIGH(1'b0)) slv0_i (
        .cs_n(cs_n[0]), .sclk(sclk[0]), .mosi(mosi[0]), .resp(resp[0]),
        .miso(miso[0]), .cmd(cmd[0]), .rises(rises[0]), .stray(stray[0]),
        .lead_t(lead_t[0]), .lag_t(lag_t[0]));

    adc_slave_model #(.IDLE_HIGH(1'b1)) slv1_i (
        .cs_n(cs_n[1]), .sclk(sclk[1]), .mosi(mosi[1]), .resp(resp[1]),
        .miso(miso[1]), .cmd(cmd[1]), .rises(rises[1]), .stray(stray[1]),
        .lead_t(lead_t[1]), .lag_t(lag_t[1]));

    function automatic int div_of(input int m);
        return (m == 0) ? 3 : 1;
    endfunction

    function automatic logic idle_of(input int m);
        return (m == 0) ? 1'b0 : 1'b1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input int m);
        @(negedge clk) start[m] = 1'b1;
        @(negedge clk) start[m] = 1'b0;
    endtask

    task automatic wait_done(input int m);
        for (int n = 0; n < 5000 && done[m] !== 1'b1; n++) @(negedge clk);
    endtask

    // Reset state of both copies (R1, R4).
    task automatic test_reset();
        for (int m = 0; m < 2; m++) begin
            check(cs_n[m] === 1'b1, "R1", "cs_n after reset", cs_n[m], 1);
            check(busy[m] === 1'b0, "R1", "busy after reset", busy[m], 0);
            check(done[m] === 1'b0, "R1", "done after reset", done[m], 0);
            check(sclk[m] === idle_of(m), "R4", "sclk idle level", sclk[m], idle_of(m));
        end
    endtask

    // One full frame with a chosen reply; checks R2 R3 R5 R6 R7 R8.
    task automatic run_frame(input int m, input bit s, input bit [2:0] c,
                             input bit [23:0] rsp);
        bit [23:0] exp_cmd;
        int        stray0;
        exp_cmd = {6'b0, 1'b1, s, c, 5'b0, 8'h00};
        stray0  = stray[m];
        resp[m] = rsp;
        sgl[m]  = s;
        ch[m]   = c;
        pulse_start(m);
        wait_done(m);
        check(done[m] === 1'b1, "R8", "done seen", done[m], 1);
        check(busy[m] === 1'b0 && cs_n[m] === 1'b1, "R8", "idle at done",
              {busy[m], cs_n[m]}, 2'b01);
        check(rises[m] == 24, "R2", "rising edges in frame", rises[m], 24);
        check(lead_t[m] >= 10 * div_of(m), "R2", "cs lead time", lead_t[m], 10 * div_of(m));
        check(lag_t[m] >= 10 * div_of(m), "R2", "cs lag time", lag_t[m], 10 * div_of(m));
        // Bits captured by the model on rising edges (R5 sample edge).
        check(cmd[m] == exp_cmd, "R3", "command word", cmd[m], exp_cmd);
        check(result[m] == rsp[12:0], "R6", "result", result[m], rsp[12:0]);
        check(null_err[m] == rsp[13], "R7", "null_err", null_err[m], rsp[13]);
        @(negedge clk);
        check(done[m] === 1'b0, "R8", "done width", done[m], 0);
        check(stray[m] == stray0, "R2", "sclk edges with cs high", stray[m], stray0);
        check(sclk[m] === idle_of(m), "R4", "sclk parked after frame", sclk[m], idle_of(m));
        repeat (3) @(negedge clk);
    endtask

    // Start during a frame is ignored; inputs changed mid-frame (R9, R10).
    task automatic test_busy_ignore(input int m);
        bit [23:0] exp_cmd;
        int        frames_cs;
        exp_cmd = {6'b0, 1'b1, 1'b1, 3'd6, 5'b0, 8'h00};
        resp[m] = 24'h000_055;
        sgl[m]  = 1'b1;
        ch[m]   = 3'd6;
        pulse_start(m);
        repeat (5) @(negedge clk);
        sgl[m] = 1'b0;
        ch[m]  = 3'd1;
        pulse_start(m);
        wait_done(m);
        check(cmd[m] == exp_cmd, "R10", "command latched at start", cmd[m], exp_cmd);
        check(rises[m] == 24, "R9", "frame not restarted", rises[m], 24);
        frames_cs = 0;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (cs_n[m] !== 1'b1 || busy[m] !== 1'b0) frames_cs++;
        end
        check(frames_cs == 0, "R9", "no extra frame after ignored start", frames_cs, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        for (int m = 0; m < 2; m++) begin
            start[m] = 1'b0; sgl[m] = 1'b0; ch[m] = 3'd0; resp[m] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        // Reply layout: 8 junk, 2 unknown, null, sign, 12 magnitude.
        run_frame(0, 1'b1, 3'd5, {8'hFF, 2'b11, 1'b0, 1'b0, 12'hABC});
        run_frame(1, 1'b1, 3'd5, {8'hFF, 2'b11, 1'b0, 1'b0, 12'hABC});
        run_frame(0, 1'b0, 3'd2, {8'hFF, 2'b11, 1'b0, 1'b1, 12'h123});
        run_frame(1, 1'b0, 3'd7, {8'hFF, 2'b11, 1'b0, 1'b1, 12'h123});
        run_frame(0, 1'b1, 3'd0, {8'h00, 2'b00, 1'b1, 1'b0, 12'h00F});
        run_frame(1, 1'b0, 3'd3, {8'hA5, 2'b01, 1'b1, 1'b1, 12'hFFF});
        run_frame(0, 1'b0, 3'd4, {8'hFF, 2'b11, 1'b0, 1'b1, 12'hFFF});
        run_frame(1, 1'b1, 3'd1, {8'hFF, 2'b11, 1'b0, 1'b0, 12'h000});
        test_busy_ignore(0);
        test_busy_ignore(1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule